// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Controller

This controller sits beside the datapath of a five-stage in-order integer pipeline: fetch, decode with register read, execute, memory and write-back. Each cycle it takes the decoded register fields and control bits of the instruction in decode. It carries them down its own copy of the pipeline control: an execute slot, a memory slot and a write-back slot. From that copy it drives the two ALU operand multiplexer selects for the instruction now in execute. Each select picks the register file value, the result waiting in the execute/memory register, or the value waiting in the memory/write-back register.

A load's data appears only at the end of the memory stage, so an instruction that reads the loaded register right after the load must wait. When the slot in execute holds such a load, the controller raises a hold on the program counter and on the fetch/decode register. It also orders a bubble into the decode/execute register: a slot whose control fields are all zero. The bubble moves down the pipe like any other slot and never forwards or stalls anything. The register file is assumed to return a value written in the same cycle, so an instruction three positions behind its producer reads it directly.

A two-state machine tracks the execute slot. FLOW means execute holds a real instruction. BUBBLE means execute holds an injected bubble. The transition FLOW to BUBBLE, called "interlock", fires on a load-use match. The transition BUBBLE to FLOW, called "resume", is taken unconditionally on the next cycle. FLOW to FLOW, called "advance", covers every other cycle. The hazard outputs are decoded from the state and the match.

Top module: `fwd_ctl_top`

## Requirements
- R1: Each operand select uses the encoding 2'b00 for the register file, 2'b01 for the execute/memory result and 2'b10 for the memory/write-back result; 2'b11 is never driven. Select A follows the first source of the instruction in execute, and select B follows the second source.
- R2: When the execute/memory and memory/write-back slots both write the source register, the select is 2'b01.
- R3: A producer whose destination is register 0, or whose reg_wr bit is 0, never causes a select other than 2'b00.
- R4: An instruction three positions behind its producer gets select 2'b00, because the register file returns a same-cycle write.
- R5: When execute holds a load (mem_rd=1, reg_wr=1, destination not 0) whose destination equals either decode source, stall_pc, stall_ifid and bubble_idex are all 1 in that same cycle.
- R6: A dependent instruction that stays in decode loses exactly one cycle. In the cycle after the stall, the hazard outputs are 0. When the instruction then reaches execute, the loaded register is selected as 2'b10.
- R7: An injected bubble carries zero control. In the cycle after a stall, both selects are 2'b00 and no stall is raised.
- R8: No stall is raised for a load whose destination is register 0 or whose reg_wr is 0, for a producer that is not a load, or for a load that is two positions ahead.
- R9: After reset, all tracked slots are empty, both selects are 2'b00 and the hazard outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_src_a | input | REG_AW | First source register of the decode instruction (0 when unused) |
| dec_src_b | input | REG_AW | Second source register of the decode instruction (0 when unused) |
| dec_dst | input | REG_AW | Destination register of the decode instruction |
| dec_reg_wr | input | 1 | Decode instruction writes dec_dst |
| dec_mem_rd | input | 1 | Decode instruction is a load |
| fwd_sel_a | output | 2 | Operand A multiplexer select |
| fwd_sel_b | output | 2 | Operand B multiplexer select |
| stall_pc | output | 1 | Hold the program counter |
| stall_ifid | output | 1 | Hold the fetch/decode register |
| bubble_idex | output | 1 | Load zero control into decode/execute |

## Verification
A slot register that loads or shifts wrongly shows at the selects as soon as the mismatched instruction reaches execute: one to three cycles after it leaves decode, depending on which slot is wrong. A state machine stuck in BUBBLE, or a bubble that keeps load control, shows in the very next cycle. The stall then persists while decode is held, instead of dropping after one cycle. A wrong priority or a missing register-0 exemption shows in the single cycle in which the two producers and the consumer line up.

// File: rtl/fwd_ctl_pkg.sv
package fwd_ctl_pkg;

    typedef enum logic [1:0] {
        SEL_RF   = 2'b00,
        SEL_EXM  = 2'b01,
        SEL_MWB  = 2'b10
    } fwd_sel_e;

    typedef enum logic {
        ST_FLOW   = 1'b0,
        ST_BUBBLE = 1'b1
    } slot_state_e;

endpackage

// File: rtl/fwd_ctl_slots.sv
module fwd_ctl_slots #(
    parameter int unsigned REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inject,
    input  logic [REG_AW-1:0] dec_src_a,
    input  logic [REG_AW-1:0] dec_src_b,
    input  logic [REG_AW-1:0] dec_dst,
    input  logic              dec_reg_wr,
    input  logic              dec_mem_rd,
    output logic [REG_AW-1:0] ex_src_a,
    output logic [REG_AW-1:0] ex_src_b,
    output logic [REG_AW-1:0] ex_dst,
    output logic              ex_reg_wr,
    output logic              ex_mem_rd,
    output logic [REG_AW-1:0] exm_dst,
    output logic              exm_reg_wr,
    output logic [REG_AW-1:0] mwb_dst,
    output logic              mwb_reg_wr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ex_src_a   <= '0;
            ex_src_b   <= '0;
            ex_dst     <= '0;
            ex_reg_wr  <= 1'b0;
            ex_mem_rd  <= 1'b0;
            exm_dst    <= '0;
            exm_reg_wr <= 1'b0;
            mwb_dst    <= '0;
            mwb_reg_wr <= 1'b0;
        end else begin
            if (inject) begin
                ex_src_a  <= '0;
                ex_src_b  <= '0;
                ex_dst    <= '0;
                ex_reg_wr <= 1'b0;
                ex_mem_rd <= 1'b0;
            end else begin
                ex_src_a  <= dec_src_a;
                ex_src_b  <= dec_src_b;
                ex_dst    <= dec_dst;
                ex_reg_wr <= dec_reg_wr;
                ex_mem_rd <= dec_mem_rd;
            end
            exm_dst    <= ex_dst;
            exm_reg_wr <= ex_reg_wr;
            mwb_dst    <= exm_dst;
            mwb_reg_wr <= exm_reg_wr;
        end
    end

endmodule

// File: rtl/fwd_ctl_bypass.sv
module fwd_ctl_bypass
    import fwd_ctl_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] exm_dst,
    input  logic              exm_reg_wr,
    input  logic [REG_AW-1:0] mwb_dst,
    input  logic              mwb_reg_wr,
    output fwd_sel_e          sel
);

    logic src_live;
    logic hit_exm;
    logic hit_mwb;

    assign src_live = (src != '0);
    assign hit_exm  = src_live && exm_reg_wr && (exm_dst == src);
    assign hit_mwb  = src_live && mwb_reg_wr && (mwb_dst == src);

    always_comb begin
        if (hit_exm)      sel = SEL_EXM;
        else if (hit_mwb) sel = SEL_MWB;
        else              sel = SEL_RF;
    end

endmodule

// File: rtl/fwd_ctl_loaduse.sv
module fwd_ctl_loaduse #(
    parameter int unsigned REG_AW = 5
) (
    input  logic [REG_AW-1:0] ex_dst,
    input  logic              ex_reg_wr,
    input  logic              ex_mem_rd,
    input  logic [REG_AW-1:0] dec_src_a,
    input  logic [REG_AW-1:0] dec_src_b,
    output logic              hit
);

    logic load_live;

    assign load_live = ex_mem_rd && ex_reg_wr && (ex_dst != '0);
    assign hit = load_live && ((ex_dst == dec_src_a) || (ex_dst == dec_src_b));

endmodule

// File: rtl/fwd_ctl_top.sv
module fwd_ctl_top
    import fwd_ctl_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] dec_src_a,
    input  logic [REG_AW-1:0] dec_src_b,
    input  logic [REG_AW-1:0] dec_dst,
    input  logic              dec_reg_wr,
    input  logic              dec_mem_rd,
    output logic [1:0]        fwd_sel_a,
    output logic [1:0]        fwd_sel_b,
    output logic              stall_pc,
    output logic              stall_ifid,
    output logic              bubble_idex
);

    localparam int unsigned NUM_SRC = 2;

    slot_state_e state_q, state_d;
    logic        lu_hit;
    logic        inject;

    logic [REG_AW-1:0] ex_src_a, ex_src_b, ex_dst, exm_dst, mwb_dst;
    logic              ex_reg_wr, ex_mem_rd, exm_reg_wr, mwb_reg_wr;
    logic [REG_AW-1:0] ex_src [NUM_SRC];
    fwd_sel_e          sel    [NUM_SRC];

    fwd_ctl_slots #(.REG_AW(REG_AW)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .inject     (inject),
        .dec_src_a  (dec_src_a),
        .dec_src_b  (dec_src_b),
        .dec_dst    (dec_dst),
        .dec_reg_wr (dec_reg_wr),
        .dec_mem_rd (dec_mem_rd),
        .ex_src_a   (ex_src_a),
        .ex_src_b   (ex_src_b),
        .ex_dst     (ex_dst),
        .ex_reg_wr  (ex_reg_wr),
        .ex_mem_rd  (ex_mem_rd),
        .exm_dst    (exm_dst),
        .exm_reg_wr (exm_reg_wr),
        .mwb_dst    (mwb_dst),
        .mwb_reg_wr (mwb_reg_wr)
    );

    fwd_ctl_loaduse #(.REG_AW(REG_AW)) u_lu (
        .ex_dst    (ex_dst),
        .ex_reg_wr (ex_reg_wr),
        .ex_mem_rd (ex_mem_rd),
        .dec_src_a (dec_src_a),
        .dec_src_b (dec_src_b),
        .hit       (lu_hit)
    );

    assign ex_src[0] = ex_src_a;
    assign ex_src[1] = ex_src_b;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
        fwd_ctl_bypass #(.REG_AW(REG_AW)) u_byp (
            .src        (ex_src[g]),
            .exm_dst    (exm_dst),
            .exm_reg_wr (exm_reg_wr),
            .mwb_dst    (mwb_dst),
            .mwb_reg_wr (mwb_reg_wr),
            .sel        (sel[g])
        );
    end

    assign fwd_sel_a = sel[0];
    assign fwd_sel_b = sel[1];

    // State register: FLOW = real instruction in execute, BUBBLE = injected slot.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FLOW;
        else        state_q <= state_d;
    end

    // Next state and hazard outputs.
    always_comb begin
        state_d     = ST_FLOW;
        inject      = 1'b0;
        unique case (state_q)
            ST_FLOW: begin
                if (lu_hit) begin
                    inject  = 1'b1;
                    state_d = ST_BUBBLE;
                end
            end
            ST_BUBBLE: begin
                inject  = 1'b0;
                state_d = ST_FLOW;
            end
            default: state_d = ST_FLOW;
        endcase
        stall_pc    = inject;
        stall_ifid  = inject;
        bubble_idex = inject;
    end

endmodule

// File: rtl/fwd_ctl_checker.sv
module fwd_ctl_checker #(
    parameter int unsigned REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        fwd_sel_a,
    input logic [1:0]        fwd_sel_b,
    input logic              stall_pc,
    input logic              stall_ifid,
    input logic              bubble_idex,
    input logic [REG_AW-1:0] ex_src_a,
    input logic [REG_AW-1:0] exm_dst,
    input logic              exm_reg_wr
);

    assert_sel_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sel_a != 2'b11) && (fwd_sel_b != 2'b11));

    assert_exm_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_src_a != '0 && exm_reg_wr && exm_dst == ex_src_a) |-> fwd_sel_a == 2'b01);

    assert_one_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall_pc |=> !stall_pc && !stall_ifid && !bubble_idex);

    assert_bubble_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_idex |=> fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00);

    assert_exm_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_src_a == '0) |-> fwd_sel_a == 2'b00);

endmodule

bind fwd_ctl_top fwd_ctl_checker #(.REG_AW(REG_AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fwd_sel_a   (fwd_sel_a),
    .fwd_sel_b   (fwd_sel_b),
    .stall_pc    (stall_pc),
    .stall_ifid  (stall_ifid),
    .bubble_idex (bubble_idex),
    .ex_src_a    (ex_src_a),
    .exm_dst     (exm_dst),
    .exm_reg_wr  (exm_reg_wr)
);

// File: tb/sim_fwd_ctl_top.sv
module sim_fwd_ctl_top;

    localparam int unsigned AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] dec_src_a = '0, dec_src_b = '0, dec_dst = '0;
    logic          dec_reg_wr = 1'b0, dec_mem_rd = 1'b0;
    logic [1:0]    fwd_sel_a, fwd_sel_b;
    logic          stall_pc, stall_ifid, bubble_idex;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    fwd_ctl_top #(.REG_AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_dst(dec_dst),
        .dec_reg_wr(dec_reg_wr), .dec_mem_rd(dec_mem_rd),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
        .stall_pc(stall_pc), .stall_ifid(stall_ifid), .bubble_idex(bubble_idex)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_stall(input string req, input int exp);
        chk(req, {29'd0, stall_pc, stall_ifid, bubble_idex}, exp ? 7 : 0);
    endtask

    // Present one decode instruction on the falling edge, settle before the rising edge.
    task automatic put(input int a, input int b, input int d, input bit wr, input bit ld);
        @(negedge clk);
        dec_src_a  = AW'(a);
        dec_src_b  = AW'(b);
        dec_dst    = AW'(d);
        dec_reg_wr = wr;
        dec_mem_rd = ld;
        #5;
    endtask

    task automatic drain();
        for (int i = 0; i < 3; i++) put(0, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        #5;
        chk("R9 sel_a", fwd_sel_a, 0);
        chk("R9 sel_b", fwd_sel_b, 0);
        chk_stall("R9 stall", 0);
    endtask

    task automatic t_basic();
        put(0, 0, 1, 1, 0);
        put(1, 0, 0, 0, 0);
        put(0, 1, 0, 0, 0);
        chk("R1 sel_a from exm", fwd_sel_a, 1);
        put(1, 1, 0, 0, 0);
        chk("R1 sel_b from mwb", fwd_sel_b, 2);
        chk("R1 sel_a none", fwd_sel_a, 0);
        put(0, 0, 0, 0, 0);
        chk("R4 sel_a rf", fwd_sel_a, 0);
        chk("R4 sel_b rf", fwd_sel_b, 0);
        drain();
    endtask

    task automatic t_priority();
        put(0, 0, 2, 1, 0);
        put(0, 0, 2, 1, 0);
        put(2, 2, 0, 0, 0);
        put(0, 0, 0, 0, 0);
        chk("R2 sel_a", fwd_sel_a, 1);
        chk("R2 sel_b", fwd_sel_b, 1);
        drain();
    endtask

    task automatic t_nowrite();
        put(0, 0, 3, 0, 0);
        put(3, 3, 0, 0, 0);
        put(0, 0, 0, 0, 0);
        chk("R3 wr0 exm", fwd_sel_a, 0);
        chk("R3 wr0 exm b", fwd_sel_b, 0);
        drain();
        put(0, 0, 3, 0, 0);
        put(0, 0, 0, 0, 0);
        put(3, 0, 0, 0, 0);
        put(0, 0, 0, 0, 0);
        chk("R3 wr0 mwb", fwd_sel_a, 0);
        drain();
    endtask

    task automatic t_loaduse_a();
        put(0, 0, 4, 1, 1);
        put(4, 0, 5, 1, 0);
        chk_stall("R5 stall on src_a", 1);
        put(4, 0, 5, 1, 0);
        chk_stall("R6 one cycle only", 0);
        chk("R7 bubble sel_a", fwd_sel_a, 0);
        chk("R7 bubble sel_b", fwd_sel_b, 0);
        put(0, 0, 0, 0, 0);
        chk("R6 load data via mwb", fwd_sel_a, 2);
        chk_stall("R7 no stall after", 0);
        drain();
    endtask

    task automatic t_loaduse_b();
        put(0, 0, 6, 1, 1);
        put(0, 6, 0, 0, 0);
        chk_stall("R5 stall on src_b", 1);
        put(0, 6, 0, 0, 0);
        chk_stall("R6 src_b released", 0);
        put(0, 0, 0, 0, 0);
        chk("R6 src_b via mwb", fwd_sel_b, 2);
        drain();
    endtask

    task automatic t_nostall();
        put(0, 0, 0, 1, 1);
        put(0, 0, 0, 0, 0);
        chk_stall("R8 load to r0", 0);
        drain();
        put(0, 0, 7, 0, 1);
        put(7, 0, 0, 0, 0);
        chk_stall("R8 load no regwr", 0);
        drain();
        put(0, 0, 9, 1, 0);
        put(9, 0, 0, 0, 0);
        chk_stall("R8 alu producer", 0);
        drain();
        put(0, 0, 8, 1, 1);
        put(0, 0, 0, 0, 0);
        put(8, 0, 0, 0, 0);
        chk_stall("R8 load two ahead", 0);
        put(0, 0, 0, 0, 0);
        chk("R8 two ahead via mwb", fwd_sel_a, 2);
        drain();
    endtask

    initial begin : watchdog
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_basic();
        t_priority();
        t_nowrite();
        t_loaduse_a();
        t_loaduse_b();
        t_nostall();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule